// File: doc/BRIEF.md
# Serial EEPROM Boot Record Loader

After reset this block pulls a boot image out of an external serial EEPROM over SPI and writes it into on-chip memories. Software is not involved. A chip-select strap, sampled when `start` pulses, decides whether to try at all. If the strap is high, the loader reads the first bytes of the EEPROM using a two-byte address. It checks them against a signature, either in place or shifted by one byte. This check tells it whether the part takes two or three address bytes.

The loader then opens one continuous read at byte 4 and parses typed records. Each record has a five-byte header and then a payload. Payload bytes for the instruction space are packed into 32-bit words. Payload bytes for the two data spaces are packed into 16-bit words. Each word is issued on a single-cycle write port that carries a space code, a word address and the data. Records of unknown type are read past and discarded. The first execute record ends the load and its address appears on `exec_addr`. If the strap is low or the signature is absent, the loader reports a skip instead.

Top module: `spi_boot_loader`

## Requirements
- R1: If `strap_cs` is 0 when `start` pulses, `done` and `skipped` are both 1 one clock later. `cs_n` stays high and SCLK never toggles.
- R2: SPI mode 0 is used. SCLK is low whenever `cs_n` is high, and MOSI changes only while SCLK is low. The probe transaction sends 0x03, 0x00, 0x00 and then reads four bytes.
- R3: If the four probe bytes equal `SIGNATURE` (first byte read = bits 31:24), the load transaction sends 0x03, 0x00, 0x04.
- R4: If only the last three probe bytes equal signature bits 31:8, the load transaction sends 0x03, 0x00, 0x00, 0x04.
- R5: If neither comparison matches, `done` and `skipped` become 1, no write occurs and `cs_n` returns high.
- R6: Records start at byte 4. Each has type at offset 0, length in bytes at offsets 1–2 (low byte first), address at offsets 3–4 (low byte first), then the payload. Type 0 writes space code 0 with 32-bit words, first byte in bits 31:24. The word address starts at the record address and rises by one per word.
- R7: Types 1 and 2 write space codes 1 and 2 with 16-bit words in bits 15:8 and 7:0, first byte high. Bits 31:16 are zero.
- R8: A payload whose length is not a multiple of the word size ends with a word that holds its remaining bytes in the top positions, zeros below.
- R9: A record of type 4 or above has its payload consumed according to its length, with no write. The following record is parsed normally.
- R10: A type 3 record sets `exec_addr` to its address field and `done`=1 with `skipped`=0. `cs_n` goes high and no write follows.
- R11: A record of length 0 produces no write. The next header begins immediately after it.
- R12: Each SCLK high phase and each low phase lasts `SCLK_HALF` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins the boot attempt |
| strap_cs | input | 1 | Sampled chip-select strap; 0 skips the boot |
| miso | input | 1 | Serial data from the EEPROM |
| sclk | output | 1 | Serial clock to the EEPROM |
| mosi | output | 1 | Serial data to the EEPROM |
| cs_n | output | 1 | EEPROM chip select, active low |
| wr_en | output | 1 | Memory write strobe, one cycle per word |
| wr_space | output | 2 | Target space: 0 instruction, 1 X data, 2 Y data |
| wr_addr | output | 16 | Word address of the write |
| wr_data | output | 32 | Write data; data spaces use bits 15:0 |
| done | output | 1 | Boot attempt finished, held until reset |
| skipped | output | 1 | Boot was skipped, held until reset |
| exec_addr | output | 16 | Address taken from the execute record |

## Verification
The strap skip is due one clock after `start`, so the bench checks `done` and `skipped` on the first falling clock edge after the pulse. Every SPI byte takes 16 × `SCLK_HALF` clocks. A packed word is strobed one clock after the falling SCLK edge that ends its last byte. The bench therefore compares each write at the falling clock edge where `wr_en` is seen, against a list worked out arithmetically from the image it built. It then waits for `done` before checking totals, the execute address and the command bytes the EEPROM model captured.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int IWORD_W = 32;
    localparam int DWORD_W = 16;
    localparam int PROBE_LAST = 6;          // command + 2 address + 4 data bytes
    localparam int HDR_LAST   = 4;          // five record header bytes

    localparam logic [BYTE_W-1:0] CMD_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] REC_START = 8'h04;
    localparam logic [BYTE_W-1:0] KIND_EXEC = 8'h03;

    typedef enum logic [1:0] {
        SP_INSTR = 2'd0,
        SP_XDATA = 2'd1,
        SP_YDATA = 2'd2,
        SP_NONE  = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_GAP,
        ST_HDR,
        ST_FIELD,
        ST_PAYLOAD,
        ST_END
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] kind;
        logic [15:0]       len;
        logic [BYTE_W-1:0] addr_lo;
    } rec_hdr_t;

    typedef struct packed {
        logic               en;
        space_e             space;
        logic [ADDR_W-1:0]  addr;
        logic [IWORD_W-1:0] data;
    } mem_wr_t;

    function automatic logic [2:0] bytes_per_word(space_e sp);
        return (sp == SP_INSTR) ? 3'(IWORD_W / BYTE_W) : 3'(DWORD_W / BYTE_W);
    endfunction

    // left-justify n collected bytes inside a word of bpw bytes
    function automatic logic [IWORD_W-1:0] justify(logic [IWORD_W-1:0] v,
                                                   logic [2:0] n, logic [2:0] bpw);
        return v << {bpw - n, 3'b000};
    endfunction

endpackage

// File: rtl/sbl_spi_byte.sv
module sbl_spi_byte
    import sbl_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx
);
    localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [DW-1:0] DLAST = DW'(SCLK_HALF - 1);

    logic [DW-1:0]     div_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            sclk  <= 1'b0;
            div_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
            rx    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    sh_q  <= tx;
                    div_q <= '0;
                    bit_q <= '0;
                    sclk  <= 1'b0;
                end
            end else if (div_q == DLAST) begin
                div_q <= '0;
                sclk  <= ~sclk;
                if (!sclk) begin
                    rx <= {rx[BYTE_W-2:0], miso};
                end else if (bit_q == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bit_q <= bit_q + 3'd1;
                    sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign mosi = busy & sh_q[BYTE_W-1];

    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi)) else $error("mosi moved with sclk high"); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("byte done longer than one cycle"); // R12

endmodule

// File: rtl/sbl_packer.sv
module sbl_packer
    import sbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  space_e            load_space,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    output mem_wr_t           wr
);
    logic [IWORD_W-1:0] acc_q;
    logic [2:0]         cnt_q;
    space_e             space_q;
    logic [ADDR_W-1:0]  addr_q;

    logic [IWORD_W-1:0] acc_n;
    logic [2:0]         cnt_n;
    logic [2:0]         bpw;
    logic               emit;

    always_comb begin
        acc_n = {acc_q[IWORD_W-BYTE_W-1:0], in_byte};
        cnt_n = cnt_q + 3'd1;
        bpw   = bytes_per_word(space_q);
        emit  = in_vld && ((cnt_n == bpw) || in_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            space_q <= SP_NONE;
            addr_q  <= '0;
            wr      <= '0;
        end else begin
            wr.en <= emit;
            if (load) begin
                acc_q   <= '0;
                cnt_q   <= '0;
                space_q <= load_space;
                addr_q  <= load_addr;
            end else if (emit) begin
                wr.space <= space_q;
                wr.addr  <= addr_q;
                wr.data  <= justify(acc_n, cnt_n, bpw);
                addr_q   <= addr_q + ADDR_W'(1);
                acc_q    <= '0;
                cnt_q    <= '0;
            end else if (in_vld) begin
                acc_q <= acc_n;
                cnt_q <= cnt_n;
            end
        end
    end

    AST_SPACE_VALID: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.space != SP_NONE)) else $error("write to no space"); // R6
    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.space != SP_INSTR) |-> (wr.data[IWORD_W-1:DWORD_W] == '0))
        else $error("data word upper half set"); // R7

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
    import sbl_pkg::*;
#(
    parameter int          SCLK_HALF = 4,
    parameter logic [31:0] SIGNATURE = 32'h564C5349
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        strap_cs,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n,
    output logic        wr_en,
    output logic [1:0]  wr_space,
    output logic [15:0] wr_addr,
    output logic [31:0] wr_data,
    output logic        done,
    output logic        skipped,
    output logic [15:0] exec_addr
);
    phase_e             phase_q;
    logic [2:0]         idx_q;
    logic [31:0]        probe_q;
    logic               wide_q;
    rec_hdr_t           hdr_q;
    logic [15:0]        rem_q;
    logic               done_q, skip_q;
    logic [ADDR_W-1:0]  exec_q;

    logic               eng_busy, eng_done, kick, active;
    logic [BYTE_W-1:0]  tx_byte, rx_byte;
    logic [2:0]         hdr_last;
    logic [31:0]        probe_n;
    logic               known, pk_load, pk_vld;
    mem_wr_t            wr;

    always_comb begin
        active   = (phase_q == ST_PROBE) || (phase_q == ST_HDR) ||
                   (phase_q == ST_FIELD) || (phase_q == ST_PAYLOAD);
        kick     = active && !eng_busy && !eng_done;
        hdr_last = wide_q ? 3'd3 : 3'd2;
        probe_n  = {probe_q[23:0], rx_byte};
        known    = hdr_q.kind < KIND_EXEC;
        pk_load  = (phase_q == ST_FIELD) && eng_done && (idx_q == 3'(HDR_LAST));
        pk_vld   = (phase_q == ST_PAYLOAD) && eng_done && known;
        tx_byte  = '0;
        if (phase_q == ST_PROBE && idx_q == 3'd0) tx_byte = CMD_READ;
        if (phase_q == ST_HDR) begin
            if (idx_q == 3'd0)          tx_byte = CMD_READ;
            else if (idx_q == hdr_last) tx_byte = REC_START;
        end
    end

    sbl_spi_byte #(.SCLK_HALF(SCLK_HALF)) u_spi (
        .clk(clk), .rst(rst), .start(kick), .tx(tx_byte), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx(rx_byte)
    );

    sbl_packer u_pack (
        .clk(clk), .rst(rst), .load(pk_load),
        .load_space(known ? space_e'(hdr_q.kind[1:0]) : SP_NONE),
        .load_addr({rx_byte, hdr_q.addr_lo}),
        .in_vld(pk_vld), .in_byte(rx_byte), .in_last(rem_q == 16'd1), .wr(wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            idx_q   <= '0;
            probe_q <= '0;
            wide_q  <= 1'b0;
            hdr_q   <= '0;
            rem_q   <= '0;
            done_q  <= 1'b0;
            skip_q  <= 1'b0;
            exec_q  <= '0;
        end else begin
            unique case (phase_q)
                ST_IDLE: if (start) begin
                    if (!strap_cs) begin
                        phase_q <= ST_END;
                        done_q  <= 1'b1;
                        skip_q  <= 1'b1;
                    end else begin
                        phase_q <= ST_PROBE;
                        idx_q   <= '0;
                    end
                end
                ST_PROBE: if (eng_done) begin
                    if (idx_q >= 3'd3) probe_q <= probe_n;
                    if (idx_q == 3'(PROBE_LAST)) begin
                        if (probe_n == SIGNATURE) begin
                            wide_q  <= 1'b0;
                            phase_q <= ST_GAP;
                        end else if (probe_n[23:0] == SIGNATURE[31:8]) begin
                            wide_q  <= 1'b1;
                            phase_q <= ST_GAP;
                        end else begin
                            phase_q <= ST_END;
                            done_q  <= 1'b1;
                            skip_q  <= 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                ST_GAP: begin
                    phase_q <= ST_HDR;
                    idx_q   <= '0;
                end
                ST_HDR: if (eng_done) begin
                    if (idx_q == hdr_last) begin
                        phase_q <= ST_FIELD;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                ST_FIELD: if (eng_done) begin
                    idx_q <= idx_q + 3'd1;
                    case (idx_q)
                        3'd0: hdr_q.kind     <= rx_byte;
                        3'd1: hdr_q.len[7:0] <= rx_byte;
                        3'd2: hdr_q.len[15:8] <= rx_byte;
                        3'd3: hdr_q.addr_lo  <= rx_byte;
                        default: begin
                            idx_q <= '0;
                            if (hdr_q.kind == KIND_EXEC) begin
                                exec_q  <= {rx_byte, hdr_q.addr_lo};
                                done_q  <= 1'b1;
                                phase_q <= ST_END;
                            end else if (hdr_q.len != 16'd0) begin
                                rem_q   <= hdr_q.len;
                                phase_q <= ST_PAYLOAD;
                            end
                        end
                    endcase
                end
                ST_PAYLOAD: if (eng_done) begin
                    rem_q <= rem_q - 16'd1;
                    if (rem_q == 16'd1) begin
                        phase_q <= ST_FIELD;
                        idx_q   <= '0;
                    end
                end
                ST_END: ;
                default: phase_q <= ST_IDLE;
            endcase
        end
    end

    assign cs_n      = !active;
    assign wr_en     = wr.en;
    assign wr_space  = wr.space;
    assign wr_addr   = wr.addr;
    assign wr_data   = wr.data;
    assign done      = done_q;
    assign skipped   = skip_q;
    assign exec_addr = exec_q;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk) else $error("sclk high without select"); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done) else $error("done dropped"); // R10
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
        skipped |-> (!wr_en && cs_n)) else $error("activity after skip"); // R5
    AST_EXEC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (done && !skipped) |=> ($stable(exec_addr) && !wr_en)) else $error("change after execute"); // R10

endmodule

// File: tb/tb_spi_boot_loader.sv
module tb_spi_boot_loader;
    localparam int HALF = 2;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, strap = 1'b1, miso = 1'b1;
    logic sclk, mosi, cs_n, wr_en, done, skipped;
    logic [1:0]  wr_space;
    logic [15:0] wr_addr, exec_addr;
    logic [31:0] wr_data;

    always #4 clk = ~clk;

    spi_boot_loader #(.SCLK_HALF(HALF)) dut (
        .clk(clk), .rst(rst), .start(start), .strap_cs(strap), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .wr_en(wr_en), .wr_space(wr_space),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .skipped(skipped),
        .exec_addr(exec_addr)
    );

    int total = 0, bad = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    int aw = 16;
    logic [7:0]  mem [0:255];
    int          bitc = 0;
    int          txn = 0;
    logic [23:0] madr = '0;
    logic [7:0]  msh = '0;
    logic [7:0]  logb [0:3][0:7];

    always @(negedge cs_n) begin
        bitc = 0;
        madr = '0;
        miso = 1'b1;
    end
    always @(posedge cs_n) if (txn < 3) txn++;
    always @(posedge sclk) if (!cs_n) begin
        msh  = {msh[6:0], mosi};
        bitc++;
        if (bitc > 8 && bitc <= 8 + aw) madr = {madr[22:0], mosi};
        if (bitc % 8 == 0 && bitc / 8 <= 8) logb[txn][bitc/8-1] = msh;
    end
    always @(negedge sclk) if (!cs_n && bitc >= 8 + aw) begin : drv
        int off;
        off  = bitc - 8 - aw;
        miso = mem[(int'(madr) + off / 8) % 256][7 - off % 8];
    end

    // ---------------- expected writes ----------------
    logic [1:0]  e_sp [0:63];
    logic [15:0] e_ad [0:63];
    logic [31:0] e_da [0:63];
    bit          e_part [0:63];
    int nexp = 0, widx = 0, wp = 0;

    function automatic logic [7:0] pay(int seed, int k);
        return 8'((seed * 17 + k * 29 + 1) & 255);
    endfunction

    task automatic put_rec(int kind, int len, int addr, int seed);
        int bpw;
        mem[wp] = 8'(kind); mem[wp+1] = 8'(len); mem[wp+2] = 8'(len >> 8);
        mem[wp+3] = 8'(addr); mem[wp+4] = 8'(addr >> 8);
        for (int k = 0; k < len; k++) mem[wp+5+k] = pay(seed, k);
        wp += 5 + len;
        if (kind < 3) begin
            bpw = (kind == 0) ? 4 : 2;
            for (int w = 0; w * bpw < len; w++) begin
                logic [31:0] word;
                word = 0;
                for (int j = 0; j < bpw; j++) begin
                    word = word << 8;
                    if (w * bpw + j < len) word = word | 32'(pay(seed, w * bpw + j));
                end
                e_sp[nexp] = 2'(kind); e_ad[nexp] = 16'(addr + w); e_da[nexp] = word;
                e_part[nexp] = ((w + 1) * bpw > len);
                nexp++;
            end
        end
    endtask

    task automatic clear_img(bit good);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
        mem[0] = 8'h56; mem[1] = good ? 8'h4C : 8'h58; mem[2] = 8'h53; mem[3] = 8'h49;
        wp = 4; nexp = 0;
    endtask

    always @(negedge clk) if (!rst && wr_en) begin
        if (widx < nexp) begin
            string tag;
            tag = e_part[widx] ? "R8" : (e_sp[widx] == 2'd0 ? "R6" : "R7");
            chk(wr_space == e_sp[widx], tag, "write space", wr_space, e_sp[widx]);
            chk(wr_addr == e_ad[widx], tag, "write address", wr_addr, e_ad[widx]);
            chk(wr_data == e_da[widx], tag, "write data", wr_data, e_da[widx]);
        end else begin
            chk(1'b0, "R9", "unexpected write", wr_addr, 0);
        end
        widx++;
    end

    // ---------------- SCLK phase monitor ----------------
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, rises = 0;
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (sclk && !sclk_prev) rises++;
        if (!cs_n) begin
            if (sclk) begin
                hi_run++;
                if (lo_run > 0) last_lo = lo_run;
                lo_run = 0;
            end else begin
                lo_run++;
                if (hi_run > 0) last_hi = hi_run;
                hi_run = 0;
            end
        end else begin
            hi_run = 0; lo_run = 0;
        end
        sclk_prev = sclk;
    end

    bit first_reset = 1'b1;

    task automatic boot(int model_aw, bit strap_v);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        txn = 0; widx = 0; rises = 0; aw = model_aw; strap = strap_v;
        @(negedge clk);
        if (first_reset) begin
            first_reset = 1'b0;
            chk(cs_n == 1'b1 && sclk == 1'b0, "R2", "reset cs_n/sclk", {cs_n, sclk}, 2'b10);
            chk(done == 1'b0 && skipped == 1'b0 && wr_en == 1'b0, "R10", "reset done/skip/wr",
                {done, skipped, wr_en}, 0);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        chk(done == 1'b1, "R10", "done reached", done, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: strap low skips one clock after start
        clear_img(1'b1);
        boot(16, 1'b0);
        chk(done == 1'b1 && skipped == 1'b1, "R1", "strap skip done/skip", {done, skipped}, 2'b11);
        repeat (60) @(negedge clk);
        chk(rises == 0 && cs_n == 1'b1, "R1", "no serial activity", rises, 0);

        // R5: signature absent
        clear_img(1'b0);
        put_rec(3, 0, 16'h1111, 0);
        nexp = 0;
        boot(16, 1'b1);
        wait_done();
        chk(skipped == 1'b1, "R5", "bad signature skipped", skipped, 1);
        repeat (40) @(negedge clk);
        chk(widx == 0 && cs_n == 1'b1, "R5", "no writes, deselected", widx, 0);
        chk(logb[0][0] == 8'h03 && logb[0][1] == 8'h00 && logb[0][2] == 8'h00, "R2",
            "probe command bytes", {logb[0][0], logb[0][1], logb[0][2]}, 24'h030000);

        // sweep of payload lengths over both address widths
        for (int m = 0; m < 2; m++) begin
            for (int len = 0; len <= 6; len++) begin
                int ex;
                clear_img(1'b1);
                put_rec(0, len, 16'h0100 + len, 3);
                put_rec(1, len, 16'h2000, 7);
                put_rec(9, len, 16'h5555, 11);      // R9 unknown kind
                put_rec(2, len + 1, 16'h03F0, 13);
                put_rec(1, 0, 16'h1234, 5);         // R11 empty record
                ex = 16'h8000 + len * 3;
                put_rec(3, 2, ex, 17);
                boot(m == 0 ? 16 : 24, 1'b1);
                wait_done();
                repeat (40) @(negedge clk);
                chk(skipped == 1'b0, "R10", "not skipped", skipped, 0);
                chk(exec_addr == 16'(ex), "R10", "execute address", exec_addr, ex);
                chk(cs_n == 1'b1, "R10", "deselected after execute", cs_n, 1);
                chk(widx == nexp, "R9", "write count (R11 empty record)", widx, nexp);
                if (m == 0)
                    chk({logb[1][0], logb[1][1], logb[1][2]} == 24'h030004, "R3",
                        "two-byte load header", {logb[1][0], logb[1][1], logb[1][2]}, 24'h030004);
                else
                    chk({logb[1][0], logb[1][1], logb[1][2], logb[1][3]} == 32'h03000004, "R4",
                        "three-byte load header",
                        {logb[1][0], logb[1][1], logb[1][2], logb[1][3]}, 32'h03000004);
            end
        end
        chk(last_hi == HALF && last_lo == HALF, "R12", "sclk phase lengths",
            {last_hi[7:0], last_lo[7:0]}, {8'(HALF), 8'(HALF)});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule